// File: doc/BRIEF.md
# Frame-Buffer Cursor Post-Modify Accelerator

This block sits between a narrow CPU bus and a larger pixel memory. The CPU never drives a pixel address itself. The block holds a cursor register that points into pixel memory, and a small table of signed step values. Each CPU access to the pixel window is passed on to a Wishbone master port, with the cursor as the address. Once that access completes, the cursor moves by the step held in the table slot that the CPU address selected. One CPU instruction therefore moves a pixel byte and repositions the cursor. Walks such as "next byte", "one row up" or "one row down and one byte right" cost no extra instructions.

The cursor and the steps are wider than the CPU data bus. An extension register holds their upper bits. On a write, the upper bits are taken from it. On a read, the upper bits are copied into it, so the CPU can fetch them with a second access. The acknowledge and read-data returns are daisy-chained: when this block is not addressed, it passes the upstream chain inputs through unchanged.

Top module: `fb_cursor_accel`

## Requirements
- R1: After reset, the cursor, the extension register and every step slot read as zero.
- R2: A cursor write (`cyc_i` and `cur_stb_i` high, `we_i` high) is acknowledged in the same cycle. It loads the cursor with `dat_i` as bits 7:0 and the extension register as bits 11:8.
- R3: A cursor read is acknowledged in the same cycle and returns cursor bits 7:0 on `dat_o`. At that clock edge, cursor bits 11:8 are copied into the extension register.
- R4: An extension write stores `dat_i[3:0]`. An extension read returns the register on `dat_o[3:0]`, with `dat_o[7:4]` zero. Both are acknowledged in the same cycle.
- R5: A step-slot access selects the slot with `adr_i`. A write loads `dat_i` as bits 7:0 and the extension register as bits 11:8. A read returns bits 7:0 and copies bits 11:8 into the extension register.
- R6: While a pixel access is active (`cyc_i` and `pix_stb_i` high):
  - `pm_cyc_o` and `pm_stb_o` are high.
  - `pm_adr_o` equals the cursor.
  - `pm_we_o`, `pm_sel_o` and `pm_dat_o` follow `we_i`, `sel_i` and `dat_i`.
  - `ack_o` equals `pm_ack_i`, and on a read `dat_o` equals `pm_dat_i`.
- R7: On the edge where a pixel access (read or write) sees `pm_ack_i`, the cursor becomes the cursor plus step slot `adr_i`. During wait states the cursor and `pm_adr_o` hold.
- R8: The cursor update is two's-complement addition modulo 2^12, so steps whose bit 11 is set move the cursor backwards and the cursor wraps past either end.
- R9: When `cyc_i` is low, or no strobe is high, `ack_o` equals `chain_ack_i`, `dat_o` equals `chain_dat_i`, and the pixel port stays idle.
- R10: When several strobes are high together, only one target is served, in the priority cursor > extension > step > pixel. The others are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_i | input | 1 | CPU bus cycle |
| cur_stb_i | input | 1 | Strobe for the cursor register |
| ext_stb_i | input | 1 | Strobe for the extension register |
| step_stb_i | input | 1 | Strobe for the step table |
| pix_stb_i | input | 1 | Strobe for the pixel window |
| we_i | input | 1 | Write enable |
| adr_i | input | 3 | Step slot select |
| sel_i | input | 1 | Byte select, forwarded to the pixel port |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data, or chained read data |
| ack_o | output | 1 | Acknowledge, or chained acknowledge |
| chain_ack_i | input | 1 | Upstream acknowledge chain |
| chain_dat_i | input | 8 | Upstream read-data chain |
| pm_cyc_o | output | 1 | Pixel port cycle |
| pm_stb_o | output | 1 | Pixel port strobe |
| pm_we_o | output | 1 | Pixel port write enable |
| pm_adr_o | output | 12 | Pixel address (the cursor) |
| pm_sel_o | output | 1 | Pixel port byte select |
| pm_dat_o | output | 8 | Pixel write data |
| pm_dat_i | input | 8 | Pixel read data |
| pm_ack_i | input | 1 | Pixel port acknowledge |

## Verification
Acknowledge, read data and every pixel-port output are combinational: they are due in the same cycle as the strobe. The bench drives each access at the falling edge and samples these outputs 1 ns later, before the rising edge. The register effects (cursor load, extension copy, step write and the post-modify step) take hold at the rising edge that closes the access. The bench observes them only through a later access, for example the next `pm_adr_o` or a cursor or extension read. For wait states, the pixel strobe is held across several edges with the acknowledge low, and the cursor is checked to have moved exactly once.

// File: rtl/fbca_pkg.sv
// Shared types for the frame-buffer cursor accelerator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fbca_pkg;

    // Target served by the current CPU access
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CUR,
        TGT_EXT,
        TGT_STEP,
        TGT_PIX
    } tgt_e;

endpackage

// File: rtl/fbca_decode.sv
// Target decoder: turns the bus cycle and the four strobes into a single
// target, using the fixed priority cursor > extension > step > pixel.
// Assumes the strobes are only meaningful while cyc_i is high.
module fbca_decode
    import fbca_pkg::*;
(
    input  logic cyc_i,
    input  logic cur_stb_i,
    input  logic ext_stb_i,
    input  logic step_stb_i,
    input  logic pix_stb_i,
    output tgt_e tgt_o
);

    // Priority selection of the served target
    always_comb begin
        if (!cyc_i)          tgt_o = TGT_NONE;
        else if (cur_stb_i)  tgt_o = TGT_CUR;
        else if (ext_stb_i)  tgt_o = TGT_EXT;
        else if (step_stb_i) tgt_o = TGT_STEP;
        else if (pix_stb_i)  tgt_o = TGT_PIX;
        else                 tgt_o = TGT_NONE;
    end

endmodule

// File: rtl/fbca_step_ram.sv
// Step table: 2**IDX_W entries of signed cursor increments, each as wide as
// the cursor. One synchronous write port and one asynchronous read port.
// Assumes a small IDX_W, so that every entry can be a register with a reset.
module fbca_step_ram #(
    parameter int IDX_W  = 3,
    parameter int PIX_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [PIX_AW-1:0] wr_word,
    output logic [PIX_AW-1:0] rd_word
);

    localparam int DEPTH = 1 << IDX_W;

    logic [PIX_AW-1:0] mem [DEPTH];

    // Clear all entries on reset; write the addressed entry on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= wr_word;
        end
    end

    // Asynchronous read of the addressed entry
    assign rd_word = mem[idx];

endmodule

// File: rtl/fbca_cursor.sv
// Cursor and extension registers. The cursor is loaded by the CPU or moved
// by a step; the move is a modulo 2**PIX_AW add. The extension register is
// written by the CPU or loaded with the upper part of a wide read.
// Assumes the load requests are mutually exclusive, as the decoder ensures.
module fbca_cursor #(
    parameter int PIX_AW = 12,
    parameter int XW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_load,
    input  logic [PIX_AW-1:0] cur_word,
    input  logic              step_go,
    input  logic [PIX_AW-1:0] step,
    input  logic              ext_load,
    input  logic [XW-1:0]     ext_word,
    output logic [PIX_AW-1:0] cursor_o,
    output logic [XW-1:0]     ext_o
);

    // Cursor register: CPU load, or post-modify add that wraps modulo 2**PIX_AW
    always_ff @(posedge clk) begin
        if (!rst_n)        cursor_o <= '0;
        else if (cur_load) cursor_o <= cur_word;
        else if (step_go)  cursor_o <= cursor_o + step;
    end

    // Extension register: holds the upper bits of wide transfers
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_o <= '0;
        else if (ext_load) ext_o <= ext_word;
    end

endmodule

// File: rtl/fb_cursor_accel.sv
// Frame-buffer cursor post-modify accelerator. A CPU-side Wishbone slave
// serves four targets: cursor, extension register, step table and pixel
// window. A pixel access is forwarded to the Wishbone master port at the
// cursor address; when it is acknowledged, the cursor moves by the addressed
// step. Register targets acknowledge in the same cycle; pixel accesses
// acknowledge together with pm_ack_i.
// Assumes DW is a multiple of 8, and PIX_AW <= 2*DW when PIX_AW > DW.
module fb_cursor_accel
    import fbca_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int PIX_AW = 12,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              cur_stb_i,
    input  logic              ext_stb_i,
    input  logic              step_stb_i,
    input  logic              pix_stb_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  adr_i,
    input  logic [DW/8-1:0]   sel_i,
    input  logic [DW-1:0]     dat_i,
    output logic [DW-1:0]     dat_o,
    output logic              ack_o,
    input  logic              chain_ack_i,
    input  logic [DW-1:0]     chain_dat_i,
    output logic              pm_cyc_o,
    output logic              pm_stb_o,
    output logic              pm_we_o,
    output logic [PIX_AW-1:0] pm_adr_o,
    output logic [DW/8-1:0]   pm_sel_o,
    output logic [DW-1:0]     pm_dat_o,
    input  logic [DW-1:0]     pm_dat_i,
    input  logic              pm_ack_i
);

    localparam bit SPLIT = PIX_AW > DW;
    localparam int XW    = SPLIT ? PIX_AW - DW : 1;

    tgt_e              tgt;
    logic [PIX_AW-1:0] cursor_q;
    logic [PIX_AW-1:0] step_word;
    logic [PIX_AW-1:0] wr_word;
    logic [XW-1:0]     ext_q;
    logic [XW-1:0]     cur_hi;
    logic [XW-1:0]     step_hi;
    logic [DW-1:0]     cur_lo;
    logic [DW-1:0]     step_lo;
    logic [DW-1:0]     ext_rd;
    logic              pix_go;
    logic              step_go;
    logic              ext_load;
    logic [XW-1:0]     ext_word;

    fbca_decode u_decode (
        .cyc_i      (cyc_i),
        .cur_stb_i  (cur_stb_i),
        .ext_stb_i  (ext_stb_i),
        .step_stb_i (step_stb_i),
        .pix_stb_i  (pix_stb_i),
        .tgt_o      (tgt)
    );

    // Split wide words into bus-sized and extension parts
    generate
        if (SPLIT) begin : g_split
            assign wr_word = {ext_q, dat_i};
            assign cur_lo  = cursor_q[DW-1:0];
            assign cur_hi  = cursor_q[PIX_AW-1:DW];
            assign step_lo = step_word[DW-1:0];
            assign step_hi = step_word[PIX_AW-1:DW];
            assign ext_rd  = DW'(ext_q);
        end else begin : g_flat
            assign wr_word = dat_i[PIX_AW-1:0];
            assign cur_lo  = DW'(cursor_q);
            assign cur_hi  = '0;
            assign step_lo = DW'(step_word);
            assign step_hi = '0;
            assign ext_rd  = '0;
        end
    endgenerate

    fbca_step_ram #(
        .IDX_W  (IDX_W),
        .PIX_AW (PIX_AW)
    ) u_steps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tgt == TGT_STEP && we_i),
        .idx     (adr_i),
        .wr_word (wr_word),
        .rd_word (step_word)
    );

    assign pix_go  = (tgt == TGT_PIX);
    assign step_go = pix_go && pm_ack_i;

    // Extension load source: CPU write, or upper bits of a cursor/step read
    always_comb begin
        ext_load = 1'b0;
        ext_word = dat_i[XW-1:0];
        case (tgt)
            TGT_EXT:  ext_load = we_i;
            TGT_CUR:  begin ext_load = !we_i; ext_word = cur_hi;  end
            TGT_STEP: begin ext_load = !we_i; ext_word = step_hi; end
            default:  ext_load = 1'b0;
        endcase
    end

    fbca_cursor #(
        .PIX_AW (PIX_AW),
        .XW     (XW)
    ) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_load (tgt == TGT_CUR && we_i),
        .cur_word (wr_word),
        .step_go  (step_go),
        .step     (step_word),
        .ext_load (ext_load),
        .ext_word (ext_word),
        .cursor_o (cursor_q),
        .ext_o    (ext_q)
    );

    // Pixel master port follows the CPU access while the window is served
    assign pm_cyc_o = pix_go;
    assign pm_stb_o = pix_go;
    assign pm_we_o  = pix_go && we_i;
    assign pm_adr_o = cursor_q;
    assign pm_sel_o = sel_i;
    assign pm_dat_o = dat_i;

    // Return path: own acknowledge and data, or the chain inputs when idle
    always_comb begin
        case (tgt)
            TGT_CUR:  begin ack_o = 1'b1;     dat_o = cur_lo;   end
            TGT_EXT:  begin ack_o = 1'b1;     dat_o = ext_rd;   end
            TGT_STEP: begin ack_o = 1'b1;     dat_o = step_lo;  end
            TGT_PIX:  begin ack_o = pm_ack_i; dat_o = pm_dat_i; end
            default:  begin ack_o = chain_ack_i; dat_o = chain_dat_i; end
        endcase
    end

endmodule

// File: rtl/fbca_chk.sv
// Checker for the frame-buffer cursor accelerator, bound to the top module.
// Relates the CPU-side ports, the pixel port and the cursor over time.
module fbca_chk #(
    parameter int PIX_AW = 12,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_i,
    input logic              cur_stb_i,
    input logic              ext_stb_i,
    input logic              step_stb_i,
    input logic              pix_stb_i,
    input logic              chain_ack_i,
    input logic [DW-1:0]     chain_dat_i,
    input logic              ack_o,
    input logic [DW-1:0]     dat_o,
    input logic              pm_cyc_o,
    input logic              pm_stb_o,
    input logic              pm_ack_i,
    input logic [PIX_AW-1:0] pm_adr_o,
    input logic [PIX_AW-1:0] cursor,
    input logic [PIX_AW-1:0] step
);

    // R9
    chain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_i && (cur_stb_i || ext_stb_i || step_stb_i || pix_stb_i))
        |-> (ack_o == chain_ack_i && dat_o == chain_dat_i && !pm_stb_o));

    // R6
    pix_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_stb_o |-> (pm_cyc_o && ack_o == pm_ack_i && pm_adr_o == cursor));

    // R7
    post_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_stb_o && pm_ack_i) |=> (cursor == PIX_AW'($past(cursor) + $past(step))));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_stb_o && !pm_ack_i) |=> $stable(cursor));

    // R10
    prio_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && cur_stb_i) |-> (ack_o && !pm_stb_o));

    // R2
    reg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && (cur_stb_i || ext_stb_i || step_stb_i)) |-> ack_o);

endmodule

bind fb_cursor_accel fbca_chk #(
    .PIX_AW (PIX_AW),
    .DW     (DW)
) i_fbca_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_i       (cyc_i),
    .cur_stb_i   (cur_stb_i),
    .ext_stb_i   (ext_stb_i),
    .step_stb_i  (step_stb_i),
    .pix_stb_i   (pix_stb_i),
    .chain_ack_i (chain_ack_i),
    .chain_dat_i (chain_dat_i),
    .ack_o       (ack_o),
    .dat_o       (dat_o),
    .pm_cyc_o    (pm_cyc_o),
    .pm_stb_o    (pm_stb_o),
    .pm_ack_i    (pm_ack_i),
    .pm_adr_o    (pm_adr_o),
    .cursor      (cursor_q),
    .step        (step_word)
);

// File: tb/test_fb_cursor_accel.sv
// Self-checking bench for fb_cursor_accel: a vector table, then directed tests.
module test_fb_cursor_accel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_i = 1'b0;
    logic        cur_stb_i = 1'b0;
    logic        ext_stb_i = 1'b0;
    logic        step_stb_i = 1'b0;
    logic        pix_stb_i = 1'b0;
    logic        we_i = 1'b0;
    logic [2:0]  adr_i = '0;
    logic [0:0]  sel_i = 1'b1;
    logic [7:0]  dat_i = '0;
    logic [7:0]  dat_o;
    logic        ack_o;
    logic        chain_ack_i = 1'b0;
    logic [7:0]  chain_dat_i = '0;
    logic        pm_cyc_o, pm_stb_o, pm_we_o;
    logic [11:0] pm_adr_o;
    logic [0:0]  pm_sel_o;
    logic [7:0]  pm_dat_o;
    logic [7:0]  pm_dat_i;
    logic        pm_ack_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Pixel memory model: read data is a fixed function of the address
    assign pm_dat_i = pm_adr_o[7:0] ^ 8'hA5;

    fb_cursor_accel i_fb_cursor_accel (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .cur_stb_i(cur_stb_i),
        .ext_stb_i(ext_stb_i), .step_stb_i(step_stb_i), .pix_stb_i(pix_stb_i),
        .we_i(we_i), .adr_i(adr_i), .sel_i(sel_i), .dat_i(dat_i),
        .dat_o(dat_o), .ack_o(ack_o), .chain_ack_i(chain_ack_i),
        .chain_dat_i(chain_dat_i), .pm_cyc_o(pm_cyc_o), .pm_stb_o(pm_stb_o),
        .pm_we_o(pm_we_o), .pm_adr_o(pm_adr_o), .pm_sel_o(pm_sel_o),
        .pm_dat_o(pm_dat_o), .pm_dat_i(pm_dat_i), .pm_ack_i(pm_ack_i)
    );

    // kind: 0 cursor, 1 extension, 2 step, 3 pixel
    typedef struct packed {
        logic [1:0]  kind;
        logic        we;
        logic [2:0]  adr;
        logic [7:0]  dat;
        logic [7:0]  exp_dat;
        logic [11:0] exp_padr;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b1, 3'd0, 8'h03, 8'h00, 12'h000}, // R4 ext <= 3
        '{2'd0, 1'b1, 3'd0, 8'h40, 8'h00, 12'h000}, // R2 cursor <= 0x340
        '{2'd1, 1'b1, 3'd0, 8'h0F, 8'h00, 12'h000}, // R4 ext <= F
        '{2'd2, 1'b1, 3'd1, 8'hB0, 8'h00, 12'h000}, // R5 step1 <= 0xFB0
        '{2'd1, 1'b1, 3'd0, 8'h00, 8'h00, 12'h000}, // R4 ext <= 0
        '{2'd2, 1'b1, 3'd2, 8'h51, 8'h00, 12'h000}, // R5 step2 <= 0x051
        '{2'd3, 1'b0, 3'd1, 8'h00, 8'hE5, 12'h340}, // R6 R7 R8 read, back 0x50
        '{2'd3, 1'b1, 3'd2, 8'h77, 8'h00, 12'h2F0}, // R6 R7 write, fwd 0x51
        '{2'd3, 1'b0, 3'd1, 8'h00, 8'hE4, 12'h341}, // R7 R8
        '{2'd0, 1'b0, 3'd0, 8'h00, 8'hF1, 12'h000}, // R3 cursor 0x2F1
        '{2'd1, 1'b0, 3'd0, 8'h00, 8'h02, 12'h000}, // R3 ext got cursor high
        '{2'd2, 1'b0, 3'd1, 8'h00, 8'hB0, 12'h000}, // R5 step1 low
        '{2'd1, 1'b0, 3'd0, 8'h00, 8'h0F, 12'h000}, // R5 ext got step high
        '{2'd0, 1'b1, 3'd0, 8'hF0, 8'h00, 12'h000}, // R2 cursor <= 0xFF0
        '{2'd3, 1'b1, 3'd2, 8'h5A, 8'h00, 12'hFF0}, // R8 wraps to 0x041
        '{2'd3, 1'b0, 3'd0, 8'h00, 8'hE4, 12'h041}, // R7 zero step
        '{2'd3, 1'b0, 3'd0, 8'h00, 8'hE4, 12'h041}, // R7 cursor unchanged
        '{2'd0, 1'b0, 3'd0, 8'h00, 8'h41, 12'h000}, // R8 cursor 0x041
        '{2'd1, 1'b0, 3'd0, 8'h00, 8'h00, 12'h000}  // R3 ext 0
    };

    // Record one check
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge (inputs settle 1 ns later)
    task automatic drive(input int kind, input logic we, input logic [2:0] adr,
                         input logic [7:0] dat, input logic ack);
        @(negedge clk);
        cyc_i      = 1'b1;
        cur_stb_i  = (kind == 0);
        ext_stb_i  = (kind == 1);
        step_stb_i = (kind == 2);
        pix_stb_i  = (kind == 3);
        we_i = we; adr_i = adr; dat_i = dat; pm_ack_i = ack;
        #1;
    endtask

    // Let the access take its clock edge, then return the bus to idle
    task automatic close();
        @(negedge clk);
        cyc_i = 1'b0; cur_stb_i = 1'b0; ext_stb_i = 1'b0;
        step_stb_i = 1'b0; pix_stb_i = 1'b0; we_i = 1'b0; pm_ack_i = 1'b0;
    endtask

    // Register read: value due in the same cycle
    task automatic rd(input int kind, input logic [2:0] adr,
                      input logic [7:0] exp, input string req);
        drive(kind, 1'b0, adr, 8'h00, 1'b0);
        check(ack_o === 1'b1, req, ack_o, 1);
        check(dat_o === exp, req, dat_o, exp);
        close();
    endtask

    task automatic wr(input int kind, input logic [2:0] adr, input logic [7:0] dat);
        drive(kind, 1'b1, adr, dat, 1'b0);
        close();
    endtask

    initial begin
        #(4 * 50000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R9: idle bus passes the chain through
        @(negedge clk);
        chain_ack_i = 1'b1; chain_dat_i = 8'h99;
        #1;
        check(ack_o === 1'b1, "R9", ack_o, 1);
        check(dat_o === 8'h99, "R9", dat_o, 8'h99);
        chain_ack_i = 1'b0; chain_dat_i = 8'h00;
        rd(0, 3'd0, 8'h00, "R1");
        rd(1, 3'd0, 8'h00, "R1");
        rd(2, 3'd5, 8'h00, "R1");

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(int'(VECS[i].kind), VECS[i].we, VECS[i].adr, VECS[i].dat, 1'b1);
            check(ack_o === 1'b1, "R2/R6 ack", ack_o, 1);
            if (!VECS[i].we)
                check(dat_o === VECS[i].exp_dat, "R3/R5/R6 data", dat_o, VECS[i].exp_dat);
            if (VECS[i].kind == 2'd3) begin
                check(pm_stb_o === 1'b1 && pm_cyc_o === 1'b1, "R6 strobe", pm_stb_o, 1);
                check(pm_adr_o === VECS[i].exp_padr, "R7 address", pm_adr_o,
                      VECS[i].exp_padr);
                check(pm_we_o === VECS[i].we, "R6 we", pm_we_o, VECS[i].we);
                if (VECS[i].we)
                    check(pm_dat_o === VECS[i].dat, "R6 wdata", pm_dat_o, VECS[i].dat);
            end else begin
                check(pm_stb_o === 1'b0, "R6 idle", pm_stb_o, 0);
            end
            close();
        end

        // R7: wait states hold the cursor; one move on the acknowledge
        drive(3, 1'b0, 3'd2, 8'h00, 1'b0);
        check(ack_o === 1'b0, "R7 wait ack", ack_o, 0);
        check(pm_adr_o === 12'h041, "R7 wait adr", pm_adr_o, 12'h041);
        @(negedge clk); #1;
        check(pm_adr_o === 12'h041, "R7 wait hold", pm_adr_o, 12'h041);
        @(negedge clk); pm_ack_i = 1'b1; #1;
        check(ack_o === 1'b1, "R7 late ack", ack_o, 1);
        check(dat_o === (8'h41 ^ 8'hA5), "R6 read data", dat_o, 8'h41 ^ 8'hA5);
        close();
        rd(0, 3'd0, 8'h92, "R7 single move");

        // R10: cursor strobe beats pixel strobe
        @(negedge clk);
        cyc_i = 1'b1; cur_stb_i = 1'b1; pix_stb_i = 1'b1; we_i = 1'b1; dat_i = 8'h22;
        #1;
        check(pm_stb_o === 1'b0, "R10 pixel idle", pm_stb_o, 0);
        check(ack_o === 1'b1, "R10 ack", ack_o, 1);
        close();
        rd(0, 3'd0, 8'h22, "R10 cursor written");

        // R10: extension strobe beats step strobe
        @(negedge clk);
        cyc_i = 1'b1; ext_stb_i = 1'b1; step_stb_i = 1'b1; we_i = 1'b1;
        adr_i = 3'd1; dat_i = 8'h07;
        #1;
        close();
        rd(1, 3'd0, 8'h07, "R10 ext written");
        rd(2, 3'd1, 8'hB0, "R10 step untouched");

        // R9: strobe without cycle is ignored
        @(negedge clk);
        pix_stb_i = 1'b1; chain_ack_i = 1'b1; chain_dat_i = 8'h3C;
        #1;
        check(ack_o === 1'b1, "R9 chain ack", ack_o, 1);
        check(dat_o === 8'h3C, "R9 chain data", dat_o, 8'h3C);
        check(pm_stb_o === 1'b0, "R9 pixel idle", pm_stb_o, 0);
        chain_ack_i = 1'b0;
        #1;
        check(ack_o === 1'b0, "R9 chain ack low", ack_o, 0);
        close();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule